// File: doc/BRIEF.md
# Read Window Pre-Alignment Adjuster

This block runs a single time, ahead of read-eye centralization, to pull read windows away from the ends of the tap range. It reads the result of one reference-pattern sweep: for every byte lane there are eight per-bit start taps, eight per-bit end taps, and a lock flag from each of the two sweep directions. For each lane it reduces these to the latest start and the earliest end. If the window is pinned at the low end of the range, the lane's eight per-bit deskew registers are raised by a saturating step. If it is pinned at the high end, two fixed deskew slots are raised by a step that wraps.

The deskew registers are reached through a single-port read-modify-write interface. The read is issued in one cycle, the data comes back in the next, and the write goes out in that same next cycle. Each lane has eight slots. A bit reaches its slot through a parameter map, so board-level pad swizzling stays outside the logic. At the end of the run the block reports the window size of each lane, a fail flag and a one-cycle done pulse.

Top module: `rwpa_adjuster`

## Requirements
- R1: After reset, done_o and fail_o are 0, dsk_rd_o and dsk_wr_o are 0, and every window size is 0.
- R2: Only the first start_i after reset starts a run. Any later start_i taken in idle raises done_o in the next cycle with fail_o = 0. It makes no deskew access and changes no window size.
- R3: Lanes are visited in ascending order. An enabled lane whose lock_lo_i or lock_hi_i bit is 0 ends the run with done_o and fail_o = 1. Earlier lanes keep their corrections. That lane and all later lanes are neither accessed nor updated.
- R4: For each enabled, locked lane, start_max is the largest of the 8 start taps and end_min is the smallest of the 8 end taps. The window size stored for the lane is (end_min − start_max + 1) mod 2^TAP_W.
- R5: If start_max ≤ 1, each bit b = 0..7 in turn has its slot raised by 10, saturating at 31. The slot is PAD_MAP[b + 8·lane]. The default map sends bit b to slot (3·b + 1) mod 8.
- R6: If end_min > 30, slot 4 and then slot 5 of the lane are raised by 10 modulo 32, without saturation.
- R7: When both conditions hold, the eight left-side updates come first and then the two right-side updates. Each access reads the value left by the previous one.
- R8: A lane whose lane_en_i bit is 0 is not lock-checked, not accessed, and keeps its window size.
- R9: Each register update is one cycle with dsk_rd_o = 1, followed by one cycle with dsk_wr_o = 1 at the same address. Read data is returned on dsk_rdata_i in the write cycle. The address is lane·8 + slot.
- R10: A run takes one cycle per lane plus two per register update. done_o rises after exactly that many cycles past the accepting edge and lasts one cycle.
- R11: start_i is ignored while a run is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request |
| lane_en_i | input | NUM_LANES | Active-lane mask |
| lock_lo_i | input | NUM_LANES | Per-lane lock, low-to-high sweep |
| lock_hi_i | input | NUM_LANES | Per-lane lock, high-to-low sweep |
| start_tap_i | input | NUM_LANES·8·TAP_W | Per-bit window start taps, bit b of lane l at index l·8+b |
| end_tap_i | input | NUM_LANES·8·TAP_W | Per-bit window end taps, same packing |
| dsk_addr_o | output | LANE_W+SLOT_W | Deskew register address |
| dsk_rd_o | output | 1 | Deskew read strobe |
| dsk_wr_o | output | 1 | Deskew write strobe |
| dsk_wdata_o | output | DSK_W | Deskew write data |
| dsk_rdata_i | input | DSK_W | Deskew read data, one cycle after the read |
| win_size_o | output | NUM_LANES·TAP_W | Per-lane window size |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | Lock failure of the last run |

## Verification
The bench targets the classification boundaries: start_max of exactly 1 and 2, and end_min of exactly 30 and 31. An off-by-one comparison would correct a window that is not pinned, or miss one that is. It puts the extreme tap on a middle bit rather than bit 0, so a reduction over the wrong bit shows up in the window size. Lanes that hit both corrections share slot 4 between the two passes, and the initial contents are chosen so that the saturating step clips and the wrapping step wraps; an adder of the wrong kind, or updates in the wrong order, leaves a different value in the register. It also covers a lock failure in a middle lane, a disabled lane with pinned taps and no lock, a negative window that must wrap, and repeat starts after a good run and after a failed run. A design that gets these wrong would touch masked lanes, carry on past a failure, or start a second run.

// File: rtl/rwpa_pkg.sv
package rwpa_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LANE,
    ST_RD,
    ST_WR
  } rwpa_state_e;

endpackage

// File: rtl/rwpa_lane_reduce.sv
module rwpa_lane_reduce #(
  parameter int LANE_BITS = 8,
  parameter int TAP_W     = 6
) (
  input  logic [LANE_BITS*TAP_W-1:0] start_taps_i,
  input  logic [LANE_BITS*TAP_W-1:0] end_taps_i,
  output logic [TAP_W-1:0]           start_max_o,
  output logic [TAP_W-1:0]           end_min_o
);

  always_comb begin
    start_max_o = '0;
    end_min_o   = '1;
    for (int b = 0; b < LANE_BITS; b++) begin
      if (start_taps_i[b*TAP_W +: TAP_W] > start_max_o)
        start_max_o = start_taps_i[b*TAP_W +: TAP_W];
      if (end_taps_i[b*TAP_W +: TAP_W] < end_min_o)
        end_min_o = end_taps_i[b*TAP_W +: TAP_W];
    end
  end

endmodule

// File: rtl/rwpa_deskew_calc.sv
module rwpa_deskew_calc #(
  parameter int DSK_W = 5,
  parameter int SHIFT = 10
) (
  input  logic [DSK_W-1:0] cur_i,
  input  logic             sat_i,
  output logic [DSK_W-1:0] new_o
);

  logic [DSK_W:0] sum;

  assign sum   = {1'b0, cur_i} + (DSK_W+1)'(SHIFT);
  // saturate only on the left-side pass; right-side pass wraps
  assign new_o = (sat_i && sum[DSK_W]) ? '1 : sum[DSK_W-1:0];

endmodule

// File: rtl/rwpa_adjuster.sv
module rwpa_adjuster
  import rwpa_pkg::*;
#(
  parameter int NUM_LANES    = 4,
  parameter int LANE_BITS    = 8,
  parameter int TAP_W        = 6,
  parameter int DSK_W        = 5,
  parameter int SLOT_W       = 3,
  parameter int SHIFT        = 10,
  parameter int LEFT_EDGE    = 1,
  parameter int RIGHT_EDGE   = 30,
  parameter int RIGHT_SLOT_A = 4,
  parameter int RIGHT_SLOT_B = 5,
  parameter logic [NUM_LANES*LANE_BITS*SLOT_W-1:0] PAD_MAP = {NUM_LANES{24'hCC55E1}},
  localparam int LANE_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1,
  localparam int ADDR_W = LANE_W + SLOT_W
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           start_i,
  input  logic [NUM_LANES-1:0]           lane_en_i,
  input  logic [NUM_LANES-1:0]           lock_lo_i,
  input  logic [NUM_LANES-1:0]           lock_hi_i,
  input  logic [NUM_LANES*LANE_BITS*TAP_W-1:0] start_tap_i,
  input  logic [NUM_LANES*LANE_BITS*TAP_W-1:0] end_tap_i,
  output logic [ADDR_W-1:0]              dsk_addr_o,
  output logic                           dsk_rd_o,
  output logic                           dsk_wr_o,
  output logic [DSK_W-1:0]               dsk_wdata_o,
  input  logic [DSK_W-1:0]               dsk_rdata_i,
  output logic [NUM_LANES*TAP_W-1:0]     win_size_o,
  output logic                           done_o,
  output logic                           fail_o
);

  localparam int LANE_TAPS_W = LANE_BITS * TAP_W;
  localparam int OP_W        = $clog2(LANE_BITS + 2);
  localparam int OP_RA       = LANE_BITS;
  localparam int OP_RB       = LANE_BITS + 1;

  rwpa_state_e                     state_q;
  logic [LANE_W-1:0]               lane_q;
  logic [OP_W-1:0]                 op_q;
  logic                            right_q;
  logic                            ran_q;
  logic                            done_q;
  logic                            fail_q;
  logic [NUM_LANES-1:0][TAP_W-1:0] win_q;

  logic [TAP_W-1:0] lane_smax [NUM_LANES];
  logic [TAP_W-1:0] lane_emin [NUM_LANES];

  // one reducer per lane; FSM picks the current one
  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    rwpa_lane_reduce #(
      .LANE_BITS(LANE_BITS),
      .TAP_W    (TAP_W)
    ) u_reduce (
      .start_taps_i(start_tap_i[l*LANE_TAPS_W +: LANE_TAPS_W]),
      .end_taps_i  (end_tap_i[l*LANE_TAPS_W +: LANE_TAPS_W]),
      .start_max_o (lane_smax[l]),
      .end_min_o   (lane_emin[l])
    );
  end

  logic [TAP_W-1:0] cur_smax, cur_emin;
  logic             lock_ok, is_left, is_right, last_lane;
  logic             left_op, has_next;
  logic [OP_W-1:0]  next_op;
  logic [SLOT_W-1:0] slot;

  assign cur_smax  = lane_smax[lane_q];
  assign cur_emin  = lane_emin[lane_q];
  assign lock_ok   = lock_lo_i[lane_q] & lock_hi_i[lane_q];
  assign is_left   = cur_smax <= TAP_W'(LEFT_EDGE);
  assign is_right  = cur_emin >  TAP_W'(RIGHT_EDGE);
  assign last_lane = lane_q == LANE_W'(NUM_LANES - 1);
  assign left_op   = op_q < OP_W'(LANE_BITS);

  always_comb begin
    has_next = 1'b0;
    next_op  = op_q;
    if (op_q < OP_W'(LANE_BITS - 1)) begin
      has_next = 1'b1;
      next_op  = op_q + OP_W'(1);
    end else if (op_q == OP_W'(LANE_BITS - 1)) begin
      has_next = right_q;
      next_op  = OP_W'(OP_RA);
    end else if (op_q == OP_W'(OP_RA)) begin
      has_next = 1'b1;
      next_op  = OP_W'(OP_RB);
    end
  end

  always_comb begin
    if (left_op)
      slot = PAD_MAP[(int'(lane_q) * LANE_BITS + int'(op_q)) * SLOT_W +: SLOT_W];
    else if (op_q == OP_W'(OP_RA))
      slot = SLOT_W'(RIGHT_SLOT_A);
    else
      slot = SLOT_W'(RIGHT_SLOT_B);
  end

  rwpa_deskew_calc #(
    .DSK_W(DSK_W),
    .SHIFT(SHIFT)
  ) u_calc (
    .cur_i(dsk_rdata_i),
    .sat_i(left_op),
    .new_o(dsk_wdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      lane_q  <= '0;
      op_q    <= '0;
      right_q <= 1'b0;
      ran_q   <= 1'b0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
      win_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            fail_q <= 1'b0;
            if (ran_q) begin
              done_q <= 1'b1;
            end else begin
              ran_q   <= 1'b1;
              lane_q  <= '0;
              state_q <= ST_LANE;
            end
          end
        end
        ST_LANE: begin
          if (!lane_en_i[lane_q]) begin
            if (last_lane) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              lane_q <= lane_q + LANE_W'(1);
            end
          end else if (!lock_ok) begin
            done_q  <= 1'b1;
            fail_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            win_q[lane_q] <= cur_emin - cur_smax + TAP_W'(1);
            right_q       <= is_right;
            if (is_left) begin
              op_q    <= '0;
              state_q <= ST_RD;
            end else if (is_right) begin
              op_q    <= OP_W'(OP_RA);
              state_q <= ST_RD;
            end else if (last_lane) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              lane_q <= lane_q + LANE_W'(1);
            end
          end
        end
        ST_RD: state_q <= ST_WR;
        ST_WR: begin
          if (has_next) begin
            op_q    <= next_op;
            state_q <= ST_RD;
          end else if (last_lane) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            lane_q  <= lane_q + LANE_W'(1);
            state_q <= ST_LANE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign dsk_rd_o   = state_q == ST_RD;
  assign dsk_wr_o   = state_q == ST_WR;
  assign dsk_addr_o = {lane_q, slot};
  assign win_size_o = win_q;
  assign done_o     = done_q;
  assign fail_o     = fail_q;

  // R9
  rd_then_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dsk_rd_o |=> dsk_wr_o && $stable(dsk_addr_o));

  // R9
  no_rd_wr_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dsk_rd_o && dsk_wr_o));

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !dsk_rd_o && !dsk_wr_o);

  // R8
  inactive_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dsk_rd_o || dsk_wr_o) |-> lane_en_i[dsk_addr_o[ADDR_W-1:SLOT_W]]);

  // R5
  left_no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dsk_wr_o && left_op) |-> dsk_wdata_o >= dsk_rdata_i);

endmodule

// File: tb/tb_rwpa_adjuster.sv
`timescale 1ns/1ps
module tb_rwpa_adjuster;
  localparam int NL = 4;
  localparam int LB = 8;
  localparam int TW = 6;
  localparam int DW = 5;
  localparam int NS = NL * 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [NL-1:0] lane_en_i = '0, lock_lo_i = '0, lock_hi_i = '0;
  logic [NL*LB*TW-1:0] start_tap_i = '0, end_tap_i = '0;
  logic [4:0] dsk_addr_o;
  logic dsk_rd_o, dsk_wr_o, done_o, fail_o;
  logic [DW-1:0] dsk_wdata_o, dsk_rdata_i;
  logic [NL*TW-1:0] win_size_o;

  always #2 clk = ~clk;

  rwpa_adjuster dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .lane_en_i(lane_en_i),
    .lock_lo_i(lock_lo_i), .lock_hi_i(lock_hi_i), .start_tap_i(start_tap_i),
    .end_tap_i(end_tap_i), .dsk_addr_o(dsk_addr_o), .dsk_rd_o(dsk_rd_o),
    .dsk_wr_o(dsk_wr_o), .dsk_wdata_o(dsk_wdata_o), .dsk_rdata_i(dsk_rdata_i),
    .win_size_o(win_size_o), .done_o(done_o), .fail_o(fail_o)
  );

  // deskew register file model
  logic [4:0] mem [NS];
  logic [4:0] mem_init [NS];
  logic load = 1'b0;
  always @(posedge clk) begin
    if (load) begin
      for (int i = 0; i < NS; i++) mem[i] <= mem_init[i];
    end else begin
      if (dsk_rd_o) dsk_rdata_i <= mem[dsk_addr_o];
      if (dsk_wr_o) mem[dsk_addr_o] <= dsk_wdata_o;
    end
  end

  int n_tests = 0, n_fail = 0;
  int smax_m[NL], emin_m[NL], win_m[NL], model_mem[NS];
  bit en_m[NL], lo_m[NL], hi_m[NL];
  int q_addr[$], q_data[$];
  string q_req[$];
  int exp_cycles;
  bit exp_fail;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int pad(int b);
    return (3 * b + 1) % 8;
  endfunction

  task automatic set_lane(int l, int smax, int emin, bit en, bit lo, bit hi);
    smax_m[l] = smax; emin_m[l] = emin; en_m[l] = en; lo_m[l] = lo; hi_m[l] = hi;
    for (int b = 0; b < LB; b++) begin
      int st, ed;
      st = (b == 5) ? smax : ((smax - 1 - b % 3) < 0 ? 0 : smax - 1 - b % 3);
      ed = (b == 6) ? emin : ((emin + 1 + b % 4) > 63 ? 63 : emin + 1 + b % 4);
      start_tap_i[(l*LB+b)*TW +: TW] = TW'(st);
      end_tap_i[(l*LB+b)*TW +: TW]   = TW'(ed);
    end
    lane_en_i[l] = en; lock_lo_i[l] = lo; lock_hi_i[l] = hi;
  endtask

  task automatic do_reset(int mul, int off);
    for (int i = 0; i < NS; i++) begin
      mem_init[i]  = 5'((i * mul + off) % 32);
      model_mem[i] = (i * mul + off) % 32;
    end
    for (int l = 0; l < NL; l++) win_m[l] = 0;
    start_i = 1'b0; rst_ni = 1'b0; load = 1'b1;
    repeat (2) @(negedge clk);
    load = 1'b0; rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic build_model(bit rep);
    q_addr.delete(); q_data.delete(); q_req.delete();
    exp_cycles = 0; exp_fail = 0;
    if (rep) return;
    for (int l = 0; l < NL; l++) begin
      bit both;
      exp_cycles += 1;
      if (!en_m[l]) continue;
      if (!(lo_m[l] && hi_m[l])) begin exp_fail = 1; break; end
      win_m[l] = (emin_m[l] - smax_m[l] + 1) & 63;
      both = (smax_m[l] <= 1) && (emin_m[l] > 30);
      if (smax_m[l] <= 1) begin
        for (int b = 0; b < LB; b++) begin
          int a, v;
          a = l * 8 + pad(b);
          v = model_mem[a] + 10;
          if (v > 31) v = 31;
          model_mem[a] = v;
          q_addr.push_back(a); q_data.push_back(v);
          q_req.push_back(both ? "R7" : "R5");
          exp_cycles += 2;
        end
      end
      if (emin_m[l] > 30) begin
        for (int s = 4; s <= 5; s++) begin
          int a, v;
          a = l * 8 + s;
          v = (model_mem[a] + 10) % 32;
          model_mem[a] = v;
          q_addr.push_back(a); q_data.push_back(v);
          q_req.push_back(both ? "R7" : "R6");
          exp_cycles += 2;
        end
      end
    end
  endtask

  task automatic run(string req_main, bit rep, int hold);
    int idx, cnt, mism;
    bit done_seen;
    build_model(rep);
    idx = 0; cnt = 0; done_seen = 0;
    start_i = 1'b1;
    @(negedge clk);
    while (!done_seen && cnt < 2000) begin
      if (cnt + 1 >= hold) start_i = 1'b0;
      if (dsk_rd_o && dsk_wr_o) chk(0, "R9", "read and write together", 1, 0);
      if (dsk_rd_o) begin
        if (idx < q_addr.size())
          chk(int'(dsk_addr_o) == q_addr[idx], "R9", "read address", int'(dsk_addr_o), q_addr[idx]);
        else
          chk(0, "R8", "unexpected read", int'(dsk_addr_o), -1);
      end
      if (dsk_wr_o) begin
        if (idx < q_addr.size()) begin
          chk(int'(dsk_addr_o) == q_addr[idx], q_req[idx], "write address", int'(dsk_addr_o), q_addr[idx]);
          chk(int'(dsk_wdata_o) == q_data[idx], q_req[idx], "write data", int'(dsk_wdata_o), q_data[idx]);
        end else begin
          chk(0, "R8", "unexpected write", int'(dsk_addr_o), -1);
        end
        idx++;
      end
      if (done_o) done_seen = 1;
      else begin cnt++; @(negedge clk); end
    end
    start_i = 1'b0;
    chk(done_seen && cnt == exp_cycles, "R10", "done cycle", cnt, exp_cycles);
    chk(idx == q_addr.size(), "R9", "update count", idx, q_addr.size());
    chk(fail_o == exp_fail, exp_fail ? "R3" : req_main, "fail flag", int'(fail_o), int'(exp_fail));
    for (int l = 0; l < NL; l++)
      chk(int'(win_size_o[l*TW +: TW]) == win_m[l], "R4", "window size", int'(win_size_o[l*TW +: TW]), win_m[l]);
    @(negedge clk);
    chk(!done_o, "R10", "done pulse width", int'(done_o), 0);
    mism = 0;
    for (int a = 0; a < NS; a++) if (int'(mem[a]) != model_mem[a]) mism++;
    chk(mism == 0, req_main, "deskew contents mismatches", mism, 0);
    repeat (4) begin
      chk(!done_o, "R11", "no extra done", int'(done_o), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset(7, 0);
    chk(!done_o, "R1", "done after reset", int'(done_o), 0);
    chk(!fail_o, "R1", "fail after reset", int'(fail_o), 0);
    chk(!dsk_rd_o && !dsk_wr_o, "R1", "access after reset", int'(dsk_rd_o | dsk_wr_o), 0);
    chk(win_size_o == '0, "R1", "window sizes after reset", int'(win_size_o), 0);

    // R4 centered windows, boundaries start_max=2 / end_min=30 untouched
    set_lane(0, 5, 25, 1, 1, 1);
    set_lane(1, 3, 20, 1, 1, 1);
    set_lane(2, 10, 28, 1, 1, 1);
    set_lane(3, 2, 30, 1, 1, 1);
    run("R4", 0, 1);

    // R5 R6 R7 R8 R11: left, right, both, inactive lane; start held 3 cycles
    do_reset(7, 0);
    set_lane(0, 1, 20, 1, 1, 1);
    set_lane(1, 6, 31, 1, 1, 1);
    set_lane(2, 0, 40, 1, 1, 1);
    set_lane(3, 0, 63, 0, 0, 0);
    run("R7", 0, 3);
    // R2 repeat start after success
    run("R2", 1, 1);

    // R3 lock failure in lane 1
    do_reset(5, 3);
    set_lane(0, 1, 20, 1, 1, 1);
    set_lane(1, 5, 20, 1, 1, 0);
    set_lane(2, 0, 10, 1, 1, 1);
    set_lane(3, 0, 40, 1, 1, 1);
    run("R3", 0, 1);
    // R2 repeat start after failure clears fail_o
    run("R2", 1, 1);

    // R4 R6 negative window wraps, mixed corrections
    do_reset(11, 9);
    set_lane(0, 40, 31, 1, 1, 1);
    set_lane(1, 1, 31, 1, 1, 1);
    set_lane(2, 1, 2, 1, 1, 1);
    set_lane(3, 4, 33, 1, 1, 1);
    run("R6", 0, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule